// File: doc/BRIEF.md
# Serial EEPROM Word Scanner with Address-Width Discovery

This block is a bus master for a three-wire serial EEPROM (select, clock, data toward the device, data from the device). After a single-cycle `start`, it first issues one throw-away read at address zero to learn how many address bits the attached part expects. A part of this kind drives its data line low for one bit (a dummy zero) as soon as it has taken in its last address bit. The block sends zero address bits one at a time and counts them until it sees that low level.

With the width known, the block reads every word of the part in ascending address order. It reports each word on a one-cycle `word_vld` strobe together with its address. It keeps a 16-bit wrapping sum of all words and, at the end, raises `done` for one cycle. The detected width, a checksum-good flag and a missing-dummy-zero flag stay on the outputs until the next start. Pin timing is set by `HALF_CYC`, the number of system clocks in each half of the serial clock.

Top module: `ser_rom_scan`

## Requirements
- R1: Every read raises `ee_cs` while `ee_sk` is low, then shifts the three command bits 1, 1, 0 (in that order) on `ee_di`.
- R2: `ee_di` is set while `ee_sk` is low and does not change while `ee_sk` is high. Each high phase of `ee_sk` lasts exactly `HALF_CYC` clocks, and each low phase lasts at least `HALF_CYC` clocks.
- R3: Address bits follow the command bits, most significant first. The discovery read sends only zeros, and no more than `ADDR_MAX` of them.
- R4: During the discovery read, `ee_do` is sampled at the end of the high phase of each address bit. A low level ends the address phase at once.
- R5: `addr_width` equals the number of address bits sent before `ee_do` was seen low. At `done` it lies between 1 and `ADDR_MAX`.
- R6: Sixteen data bits are sampled at the end of each high phase, most significant first. A normal read then gives one single-cycle `word_vld` with the word on `word_data` and its address on `word_addr`.
- R7: Whenever `ee_cs` is low, `ee_sk` and `ee_di` are low as well. After every word, all three pins go low for at least `HALF_CYC` clocks.
- R8: After discovery, the words at addresses 0 to 2^`addr_width`−1 are each reported exactly once, in ascending order. The data from the discovery read is not reported.
- R9: `sum_ok` is 1 at `done` exactly when the 16-bit wrapping sum of all reported words equals 0xBABA.
- R10: If no low level is seen within `ADDR_MAX` address bits, `size_err` is set, `addr_width` becomes `ADDR_MAX`, and all 2^`ADDR_MAX` words are still read.
- R11: After reset, all outputs are 0. `done` is a single-cycle pulse after the last word, and `addr_width`, `sum_ok` and `size_err` keep their values after it.
- R12: A `start` pulse while a scan is in progress is ignored, and the word stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a scan |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| word_vld | output | 1 | One-cycle strobe for a word read |
| word_data | output | WORD_W | Word just read |
| word_addr | output | ADDR_MAX | Address of the word just read |
| done | output | 1 | One-cycle pulse when the scan ends |
| addr_width | output | $clog2(ADDR_MAX+1) | Detected address width |
| sum_ok | output | 1 | Word sum matched the signature |
| size_err | output | 1 | No dummy zero was seen |

## Verification
The properties assume that `ee_do` is stable at the end of each serial-clock high phase. They also assume that the device drives its dummy zero only after a rising edge of `ee_sk`, so that the sampled value reflects the last bit clocked in. The bench's EEPROM model changes `ee_do` only on the rising edge of `ee_sk` or when `ee_cs` falls, which is always at least `HALF_CYC` clocks before the block samples. The model returns to a high idle level between reads, and `start` is driven only away from the active clock edge. A part that never answers is modelled by keeping `ee_do` high.

// File: rtl/ser_rom_pkg.sv
package ser_rom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEL  = 3'd1,
        ST_LO   = 3'd2,
        ST_HI   = 3'd3,
        ST_GAP  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        SG_CMD  = 2'd0,
        SG_ADR  = 2'd1,
        SG_DAT  = 2'd2
    } seg_e;

    localparam logic [2:0] READ_CMD = 3'b110;

endpackage

// File: rtl/ser_rom_tick.sv
module ser_rom_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF_CYC - 1));
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/ser_rom_shift.sv
module ser_rom_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (en) begin
            sh_d = {sh_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q;
endmodule

// File: rtl/ser_rom_sum.sv
module ser_rom_sum #(
    parameter int          W   = 16,
    parameter logic [15:0] SIG = 16'hBABA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] data,
    output logic         match
);
    logic [W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add) begin
            sum_d = sum_q + data;
        end
        match = (sum_d == W'(SIG));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end
endmodule

// File: rtl/ser_rom_scan.sv
module ser_rom_scan
    import ser_rom_pkg::*;
#(
    parameter int          HALF_CYC  = 4,
    parameter int          ADDR_MAX  = 8,
    parameter int          WORD_W    = 16,
    parameter logic [15:0] SIGNATURE = 16'hBABA
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          ee_cs,
    output logic                          ee_sk,
    output logic                          ee_di,
    input  logic                          ee_do,
    output logic                          word_vld,
    output logic [WORD_W-1:0]             word_data,
    output logic [ADDR_MAX-1:0]           word_addr,
    output logic                          done,
    output logic [$clog2(ADDR_MAX+1)-1:0] addr_width,
    output logic                          sum_ok,
    output logic                          size_err
);
    localparam int AW_W   = $clog2(ADDR_MAX + 1);
    localparam int BN_MAX = (WORD_W > ADDR_MAX) ? WORD_W : ADDR_MAX;
    localparam int BN_W   = $clog2(BN_MAX);
    localparam int CNT_W  = ADDR_MAX + 1;

    typedef struct packed {
        phase_e              st;
        seg_e                seg;
        logic [BN_W-1:0]     bitn;
        logic                detect;
        logic [AW_W-1:0]     width;
        logic                err;
        logic [ADDR_MAX-1:0] addr;
        logic                vld;
        logic                done;
        logic                ok;
    } reg_t;

    reg_t r_d, r_q;

    logic tick;
    logic sh_en;
    logic acc_clr;
    logic acc_match;
    logic last_word;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] word_cnt;
    logic bit_out;

    ser_rom_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st != ST_IDLE),
        .tick  (tick)
    );

    ser_rom_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_en),
        .din   (ee_do),
        .q     (word_data)
    );

    ser_rom_sum #(.W(WORD_W), .SIG(SIGNATURE)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .add   (r_q.vld),
        .data  (word_data),
        .match (acc_match)
    );

    // end-of-scan detection: next address equals the word count
    always_comb begin
        nxt_cnt   = {1'b0, r_q.addr} + CNT_W'(1);
        word_cnt  = CNT_W'(1) << r_q.width;
        last_word = (nxt_cnt == word_cnt);
    end

    // bit presented on the data pin for the current segment
    always_comb begin
        int idx;
        bit_out = 1'b0;
        idx     = int'(r_q.width) - 1 - int'(r_q.bitn);
        case (r_q.seg)
            SG_CMD: begin
                bit_out = READ_CMD[2 - int'(r_q.bitn[1:0])];
            end
            SG_ADR: begin
                if (!r_q.detect && idx >= 0 && idx < ADDR_MAX) begin
                    bit_out = r_q.addr[idx];
                end
            end
            default: bit_out = 1'b0;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.done = 1'b0;
        acc_clr  = 1'b0;
        sh_en    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_SEL;
                    r_d.detect = 1'b1;
                    r_d.width  = '0;
                    r_d.err    = 1'b0;
                    r_d.ok     = 1'b0;
                    r_d.addr   = '0;
                    acc_clr    = 1'b1;
                end
            end
            ST_SEL: begin
                if (tick) begin
                    r_d.st   = ST_LO;
                    r_d.seg  = SG_CMD;
                    r_d.bitn = '0;
                end
            end
            ST_LO: begin
                if (tick) begin
                    r_d.st = ST_HI;
                end
            end
            ST_HI: begin
                if (tick) begin
                    r_d.st = ST_LO;
                    case (r_q.seg)
                        SG_CMD: begin
                            if (r_q.bitn == BN_W'(2)) begin
                                r_d.seg  = SG_ADR;
                                r_d.bitn = '0;
                            end else begin
                                r_d.bitn = r_q.bitn + BN_W'(1);
                            end
                        end
                        SG_ADR: begin
                            if (r_q.detect) begin
                                if (!ee_do) begin
                                    r_d.width = AW_W'(r_q.bitn) + AW_W'(1);
                                    r_d.seg   = SG_DAT;
                                    r_d.bitn  = '0;
                                end else if (r_q.bitn == BN_W'(ADDR_MAX - 1)) begin
                                    r_d.width = AW_W'(ADDR_MAX);
                                    r_d.err   = 1'b1;
                                    r_d.seg   = SG_DAT;
                                    r_d.bitn  = '0;
                                end else begin
                                    r_d.bitn = r_q.bitn + BN_W'(1);
                                end
                            end else if (AW_W'(r_q.bitn) + AW_W'(1) == r_q.width) begin
                                r_d.seg  = SG_DAT;
                                r_d.bitn = '0;
                            end else begin
                                r_d.bitn = r_q.bitn + BN_W'(1);
                            end
                        end
                        default: begin
                            sh_en = 1'b1;
                            if (r_q.bitn == BN_W'(WORD_W - 1)) begin
                                r_d.st  = ST_GAP;
                                r_d.vld = !r_q.detect;
                            end else begin
                                r_d.bitn = r_q.bitn + BN_W'(1);
                            end
                        end
                    endcase
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.detect) begin
                        r_d.detect = 1'b0;
                        r_d.addr   = '0;
                        r_d.st     = ST_SEL;
                    end else if (last_word) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.ok   = acc_match;
                    end else begin
                        r_d.addr = r_q.addr + ADDR_MAX'(1);
                        r_d.st   = ST_SEL;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ee_cs      = (r_q.st == ST_SEL) || (r_q.st == ST_LO) || (r_q.st == ST_HI);
    assign ee_sk      = (r_q.st == ST_HI);
    assign ee_di      = ((r_q.st == ST_LO) || (r_q.st == ST_HI)) ? bit_out : 1'b0;
    assign word_vld   = r_q.vld;
    assign word_addr  = r_q.addr;
    assign done       = r_q.done;
    assign addr_width = r_q.width;
    assign sum_ok     = r_q.ok;
    assign size_err   = r_q.err;
endmodule

// File: rtl/ser_rom_scan_chk.sv
module ser_rom_scan_chk #(
    parameter int ADDR_MAX = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ee_cs,
    input logic                          ee_sk,
    input logic                          ee_di,
    input logic                          word_vld,
    input logic                          done,
    input logic [$clog2(ADDR_MAX+1)-1:0] addr_width,
    input logic                          size_err
);
    p_cs_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sk);

    p_di_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    p_width_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (addr_width != 0 && int'(addr_width) <= ADDR_MAX));

    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> (!ee_sk && !ee_di));

    p_err_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && size_err) |-> (int'(addr_width) == ADDR_MAX));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !ee_cs));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_vld, done}));
endmodule

bind ser_rom_scan ser_rom_scan_chk #(.ADDR_MAX(ADDR_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .word_vld   (word_vld),
    .done       (done),
    .addr_width (addr_width),
    .size_err   (size_err)
);

// File: tb/ser_rom_scan_test.sv
module ser_rom_scan_test;
    localparam int HALF = 2;
    localparam int AMAX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mdo = 1'b1;
    logic ee_cs, ee_sk, ee_di;
    logic word_vld, done, sum_ok, size_err;
    logic [15:0] word_data;
    logic [AMAX-1:0] word_addr;
    logic [3:0] addr_width;

    always #10 clk = ~clk;

    ser_rom_scan #(.HALF_CYC(HALF), .ADDR_MAX(AMAX), .WORD_W(16), .SIGNATURE(16'hBABA)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(mdo),
        .word_vld(word_vld), .word_data(word_data), .word_addr(word_addr),
        .done(done), .addr_width(addr_width), .sum_ok(sum_ok), .size_err(size_err)
    );

    int checks = 0;
    int fails = 0;
    bit hung = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // behavioural EEPROM: m_aw > AMAX models a part that never gives the dummy zero
    logic [15:0] mem [0:255];
    int m_aw = 6;
    int mbit = 0;
    logic [2:0] mop = '0;
    logic [7:0] maddr = '0;
    bit m_first = 0;
    int m_next = 0;

    always @(posedge ee_sk or negedge ee_cs) begin
        int len;
        len = (m_aw > AMAX) ? AMAX : m_aw;
        if (!ee_cs) begin
            if (mbit > 0) begin
                if (m_first) m_first = 0;
                else m_next++;
            end
            mbit = 0;
            maddr = '0;
            mdo = 1'b1;
        end else begin
            mbit++;
            if (mbit <= 3) begin
                mop = {mop[1:0], ee_di};
                if (mbit == 3) chk(mop == 3'b110, "R1 command bits", int'(mop), 6);
            end else if (mbit <= 3 + len) begin
                maddr = {maddr[6:0], ee_di};
                if (mbit == 3 + len) begin
                    // R3: zeros during discovery, ascending addresses afterwards
                    chk(int'(maddr) == (m_first ? 0 : m_next), "R3 address bits", int'(maddr),
                        m_first ? 0 : m_next);
                    if (m_aw <= AMAX) mdo = 1'b0;
                end
            end else if (mbit <= 3 + len + 16) begin
                if (m_aw <= AMAX) mdo = mem[maddr][15 - (mbit - 4 - len)];
                else mdo = 1'b1;
            end else begin
                mdo = 1'b1;
            end
        end
    end

    // reference stream of expected words
    int qa[$];
    logic [15:0] qd[$];

    int hi_cnt = 0;
    int lo_cnt = 0;
    logic prev_sk = 1'b0;
    logic prev_cs = 1'b0;
    logic di_hold = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ee_cs && (ee_sk || ee_di)) chk(0, "R7 pins idle with select low", {ee_sk, ee_di}, 0);
            if (!ee_cs && prev_cs) chk(!ee_sk && !ee_di, "R7 pins low after word", {ee_sk, ee_di}, 0);
            if (ee_sk) begin
                hi_cnt++;
                if (!prev_sk) begin
                    di_hold = ee_di;
                    chk(lo_cnt >= HALF, "R2 low time", lo_cnt, HALF);
                end else if (ee_di != di_hold) begin
                    chk(0, "R2 data stable while clock high", ee_di, di_hold);
                end
                lo_cnt = 0;
            end else begin
                if (prev_sk) begin
                    chk(hi_cnt == HALF, "R2 high time", hi_cnt, HALF);
                end
                hi_cnt = 0;
                lo_cnt++;
            end
            if (word_vld) begin
                if (qa.size() == 0) begin
                    chk(0, "R8 unexpected word", int'(word_addr), -1);
                end else begin
                    int ea;
                    logic [15:0] ed;
                    ea = qa.pop_front();
                    ed = qd.pop_front();
                    chk(int'(word_addr) == ea, "R8 word order", int'(word_addr), ea);
                    chk(word_data == ed, "R6 word data", int'(word_data), int'(ed));
                end
            end
            prev_sk = ee_sk;
            prev_cs = ee_cs;
        end
    end

    task automatic run_case(input int aw, input bit good, input bit poke);
        int n;
        int ew;
        bit eerr;
        bit eok;
        logic [15:0] s;
        int t;
        if (hung) return;
        n = (aw > AMAX) ? (1 << AMAX) : (1 << aw);
        ew = (aw > AMAX) ? AMAX : aw;
        eerr = (aw > AMAX);
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h03A5 + aw * 16'h0111) ^ 16'h05C3;
        s = '0;
        for (int i = 0; i < n - 1; i++) s = s + mem[i];
        mem[n - 1] = 16'hBABA - s;
        if (!good) mem[n - 1] = mem[n - 1] ^ 16'h0100;
        s = '0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = (aw > AMAX) ? 16'hFFFF : mem[i];
            qa.push_back(i);
            qd.push_back(w);
            s = s + w;
        end
        eok = (s == 16'hBABA);
        m_aw = aw;
        m_first = 1;
        m_next = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 60000) begin
            @(negedge clk);
            t++;
            // R12: a start pulse in mid-scan must leave the stream untouched
            start = (poke && t == 2000);
        end
        start = 1'b0;
        if (!done) begin
            chk(0, "watchdog", t, 0);
            hung = 1;
            return;
        end
        chk(int'(addr_width) == ew, "R5 detected width", int'(addr_width), ew);
        chk(size_err == eerr, "R10 missing dummy flag", size_err, eerr);
        chk(sum_ok == eok, "R9 checksum flag", sum_ok, eok);
        chk(qa.size() == 0, "R8 all words reported", qa.size(), 0);
        @(negedge clk);
        chk(!done, "R11 done is a pulse", done, 0);
        chk(int'(addr_width) == ew && sum_ok == eok && size_err == eerr,
            "R11 results held", int'({sum_ok, size_err, addr_width}), int'({eok, eerr, 4'(ew)}));
        qa.delete();
        qd.delete();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!ee_cs && !ee_sk && !ee_di && !word_vld && !done && addr_width == 0 && !sum_ok && !size_err,
            "R11 reset state", int'({ee_cs, ee_sk, ee_di, word_vld, done, sum_ok, size_err}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_case(6, 1'b1, 1'b1);   // R4 R5 R9 R12: width 6, good sum, stray start
        run_case(3, 1'b0, 1'b0);   // R9: corrupted sum
        run_case(8, 1'b1, 1'b0);   // R5: widest width with a dummy zero
        run_case(9, 1'b0, 1'b0);   // R10: device never answers
        run_case(1, 1'b1, 1'b0);   // R4: dummy zero after the first bit
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule